// File: doc/BRIEF.md
# Lockstep Pipeline Stage Comparator with Re-execution Control

This block sits beside a six-stage in-order pipeline (fetch, decode, register read, execute, memory access, write-back) that runs in lockstep with a partner copy. For every stage it takes this core's stage result and the partner core's stage result. Each result carries a valid bit, a data bus and an instruction tag made of a PC and a sub-PC. All of these are first stored in a capture register. The comparison runs on the captured values in the next cycle. When any stage disagrees, the block issues a one-cycle flush and a redirect. The redirect carries the PC and sub-PC of the failing sub-instruction, and fetch restarts from that point in the same way it would after a mispredicted branch.

An instruction that writes more than one register is split into sub-instructions, each with its own sub-PC. A retry therefore resumes at the failing part and does not repeat a part that is already done. For example, the base-register update of a post-increment load is not applied a second time when the memory read fails. The block records the restart point of an open re-execution. A new error seen before that point has retired cleanly sends fetch back to the same recorded point, so a retry can itself be retried. A saturating count of re-executions since the last clean completion lets a supervisor recognise a fault that persists.

Each core holds its own copy of this block and wires its own results to the local inputs and the other core's results to the partner inputs. A stuck fault inside one copy therefore leaves the other copy able to detect errors and steer recovery.

Top module: `lsc_top`

## Requirements
- R1: A stage disagreement presented at the inputs before clock edge N is stored at edge N, compared during the following cycle, and shows on `flush`, `err_pulse` and the redirect outputs after edge N+1.
- R2: A stage disagrees when exactly one side is valid, or when both sides are valid and the data, the PC or the sub-PC differ.
- R3: A stage in which both sides are invalid never causes an error, whatever its data and tags hold.
- R4: On an error that starts a new re-execution, `redir_pc`/`redir_sub` equal this core's PC and sub-PC of the failing stage, and `flush` and `err_pulse` are high for exactly one cycle.
- R5: When several stages disagree in the same cycle, the redirect uses the oldest one. Stage index 5 (write-back) is the oldest and index 0 (fetch) the youngest.
- R6: The redirect keeps sub-PC granularity. If the memory-access stage fails on sub-PC 1 of a PC while sub-PC 0 of the same PC retires cleanly in write-back, the redirect is that PC with sub-PC 1.
- R7: Stage inputs presented in the cycle in which an error is decided and in the flush cycle are discarded, so one fault event causes only one flush.
- R8: An error detected while a re-execution is open redirects to the recorded restart point, whichever stage failed.
- R9: A re-execution closes when the write-back stage shows both sides valid, in agreement, with a tag equal to the restart point. A clean retirement with any other tag leaves it open.
- R10: `retry_cnt` increases by one on every flush and saturates at 2^CNT_W-1. It returns to 0 one cycle after the re-execution closes. A new error in the same cycle as the close leaves it at 1.
- R11: After reset, `flush`, `err_pulse`, the redirect outputs and `retry_cnt` are 0 and no re-execution is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_vld | input | STAGES | This core's per-stage valid bits |
| loc_data | input | STAGES*DATA_W | This core's per-stage result buses |
| loc_pc | input | STAGES*PC_W | This core's per-stage PC tags |
| loc_sub | input | STAGES*SUB_W | This core's per-stage sub-PC tags |
| prt_vld | input | STAGES | Partner core's per-stage valid bits |
| prt_data | input | STAGES*DATA_W | Partner core's per-stage result buses |
| prt_pc | input | STAGES*PC_W | Partner core's per-stage PC tags |
| prt_sub | input | STAGES*SUB_W | Partner core's per-stage sub-PC tags |
| flush | output | 1 | One-cycle pipeline flush request |
| err_pulse | output | 1 | One-cycle error indication |
| redir_pc | output | PC_W | PC to load into the fetch stage |
| redir_sub | output | SUB_W | Sub-PC to restart from |
| retry_cnt | output | CNT_W | Saturating count of re-executions since last clean completion |

## Verification
The assertions check four things on every cycle: a flush never lasts two cycles, the counter is nonzero whenever a flush is out and holds once saturated, an error during an open retry redirects to the recorded point, and the capture registers come up empty after a clear. Only the bench scenarios can show the rest. That covers which stage wins when several disagree, which tag the redirect carries, that both-invalid stages are ignored, when a retry closes and when it stays open, and how the count behaves when a close and a new error land in the same cycle. The bench sweeps every stage under each kind of disagreement and every pair of stages that fail together.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // Depth of the in-order pipeline; index 0 is fetch, the last is write-back.
  localparam int PIPE_STAGES = 6;
endpackage

// File: rtl/lsc_stage_cmp.sv
module lsc_stage_cmp #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              l_vld,
  input  logic [DATA_W-1:0] l_data,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic              p_vld,
  input  logic [DATA_W-1:0] p_data,
  input  logic [TAG_W-1:0]  p_tag,
  output logic              mism,
  output logic              clean,
  output logic [TAG_W-1:0]  tag_q
);

  logic              lv_q, pv_q;
  logic [DATA_W-1:0] ld_q, pd_q;
  logic [TAG_W-1:0]  pt_q;

  // Capture stage results; compare happens on the stored copy next cycle.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lv_q  <= 1'b0;
      pv_q  <= 1'b0;
      ld_q  <= '0;
      pd_q  <= '0;
      tag_q <= '0;
      pt_q  <= '0;
    end else begin
      lv_q  <= l_vld;
      pv_q  <= p_vld;
      ld_q  <= l_data;
      pd_q  <= p_data;
      tag_q <= l_tag;
      pt_q  <= p_tag;
    end
  end

  always_comb begin
    mism  = (lv_q || pv_q) && ((lv_q != pv_q) || (ld_q != pd_q) || (tag_q != pt_q));
    clean = lv_q && pv_q && !mism;
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (!lv_q && !pv_q)) else $error("capture not emptied after clear"); // R7

endmodule

// File: rtl/lsc_oldest_pick.sv
module lsc_oldest_pick #(
  parameter int STAGES = 6,
  parameter int TAG_W  = 34
) (
  input  logic [STAGES-1:0]            mism,
  input  logic [STAGES-1:0][TAG_W-1:0] tags,
  output logic                         any,
  output logic [TAG_W-1:0]             tag
);

  // Ascending scan: a higher index (older stage) overwrites a younger one.
  always_comb begin
    any = 1'b0;
    tag = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (mism[i]) begin
        any = 1'b1;
        tag = tags[i];
      end
    end
  end

endmodule

// File: rtl/lsc_retry_ctl.sv
module lsc_retry_ctl #(
  parameter int TAG_W = 34,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_any,
  input  logic [TAG_W-1:0] err_tag,
  input  logic             wb_clean,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             flush_q,
  output logic             err_q,
  output logic [TAG_W-1:0] redir_q,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             in_retry_q;
  logic [TAG_W-1:0] anchor_q;
  logic             done;
  logic             nested;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    done     = in_retry_q && wb_clean && (wb_tag == anchor_q);
    nested   = in_retry_q && !done;
    cnt_base = done ? '0 : cnt_q;
    cnt_inc  = (cnt_base == CNT_MAX) ? cnt_base : cnt_base + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q    <= 1'b0;
      err_q      <= 1'b0;
      redir_q    <= '0;
      cnt_q      <= '0;
      in_retry_q <= 1'b0;
      anchor_q   <= '0;
    end else if (err_any) begin
      flush_q    <= 1'b1;
      err_q      <= 1'b1;
      in_retry_q <= 1'b1;
      cnt_q      <= cnt_inc;
      if (nested) begin
        redir_q <= anchor_q;
      end else begin
        redir_q  <= err_tag;
        anchor_q <= err_tag;
      end
    end else begin
      flush_q <= 1'b0;
      err_q   <= 1'b0;
      if (done) begin
        in_retry_q <= 1'b0;
        cnt_q      <= '0;
      end
    end
  end

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    flush_q |=> !flush_q) else $error("flush longer than one cycle"); // R7
  AST_CNT_ON_FLUSH: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> (cnt_q != '0)) else $error("flush with zero retry count"); // R10
  AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == CNT_MAX) && !done) |=> (cnt_q == CNT_MAX)) else $error("saturated count moved"); // R10
  AST_NEST_TO_ANCHOR: assert property (@(posedge clk) disable iff (rst)
    (nested && err_any) |=> (redir_q == $past(anchor_q))) else $error("nested retry left anchor"); // R8

endmodule

// File: rtl/lsc_top.sv
module lsc_top #(
  parameter int STAGES = lsc_pkg::PIPE_STAGES,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int SUB_W  = 2,
  parameter int CNT_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [STAGES-1:0]             loc_vld,
  input  logic [STAGES-1:0][DATA_W-1:0] loc_data,
  input  logic [STAGES-1:0][PC_W-1:0]   loc_pc,
  input  logic [STAGES-1:0][SUB_W-1:0]  loc_sub,
  input  logic [STAGES-1:0]             prt_vld,
  input  logic [STAGES-1:0][DATA_W-1:0] prt_data,
  input  logic [STAGES-1:0][PC_W-1:0]   prt_pc,
  input  logic [STAGES-1:0][SUB_W-1:0]  prt_sub,
  output logic                          flush,
  output logic                          err_pulse,
  output logic [PC_W-1:0]               redir_pc,
  output logic [SUB_W-1:0]              redir_sub,
  output logic [CNT_W-1:0]              retry_cnt
);

  localparam int TAG_W  = PC_W + SUB_W;
  localparam int WB_IDX = STAGES - 1;

  logic [STAGES-1:0]            mism;
  logic [STAGES-1:0]            clean;
  logic [STAGES-1:0][TAG_W-1:0] tag_q;
  logic                         err_any;
  logic [TAG_W-1:0]             err_tag;
  logic [TAG_W-1:0]             redir_tag;
  logic                         clr;

  // Drop stage inputs in the deciding cycle and in the flush cycle.
  assign clr = err_any || flush;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    lsc_stage_cmp #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W)
    ) u_cmp (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .l_vld  (loc_vld[g]),
      .l_data (loc_data[g]),
      .l_tag  ({loc_pc[g], loc_sub[g]}),
      .p_vld  (prt_vld[g]),
      .p_data (prt_data[g]),
      .p_tag  ({prt_pc[g], prt_sub[g]}),
      .mism   (mism[g]),
      .clean  (clean[g]),
      .tag_q  (tag_q[g])
    );
  end

  lsc_oldest_pick #(
    .STAGES (STAGES),
    .TAG_W  (TAG_W)
  ) u_pick (
    .mism (mism),
    .tags (tag_q),
    .any  (err_any),
    .tag  (err_tag)
  );

  lsc_retry_ctl #(
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .err_any  (err_any),
    .err_tag  (err_tag),
    .wb_clean (clean[WB_IDX]),
    .wb_tag   (tag_q[WB_IDX]),
    .flush_q  (flush),
    .err_q    (err_pulse),
    .redir_q  (redir_tag),
    .cnt_q    (retry_cnt)
  );

  assign redir_pc  = redir_tag[TAG_W-1:SUB_W];
  assign redir_sub = redir_tag[SUB_W-1:0];

  AST_FLUSH_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flush) |-> $past(err_any)) else $error("flush without a detected mismatch"); // R1

endmodule

// File: tb/tb_lsc_top.sv
module tb_lsc_top;
  localparam int NS = 6;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]       lv, pv;
  logic [NS-1:0][7:0]  ld, pd, lpc, ppc;
  logic [NS-1:0][1:0]  lsub, psub;
  logic                flush, err_pulse;
  logic [7:0]          redir_pc;
  logic [1:0]          redir_sub;
  logic [CW-1:0]       retry_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lsc_top #(.STAGES(NS), .DATA_W(8), .PC_W(8), .SUB_W(2), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst),
    .loc_vld(lv), .loc_data(ld), .loc_pc(lpc), .loc_sub(lsub),
    .prt_vld(pv), .prt_data(pd), .prt_pc(ppc), .prt_sub(psub),
    .flush(flush), .err_pulse(err_pulse), .redir_pc(redir_pc),
    .redir_sub(redir_sub), .retry_cnt(retry_cnt)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    finished = 1'b1;
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    lv = '0; pv = '0; ld = '0; pd = '0;
    lpc = '0; ppc = '0; lsub = '0; psub = '0;
  endtask

  // Both sides valid and equal on stage s.
  task automatic put_same(int s, logic [7:0] pc, logic [1:0] sb);
    lv[s] = 1'b1; pv[s] = 1'b1; ld[s] = 8'hA5; pd[s] = 8'hA5;
    lpc[s] = pc; ppc[s] = pc; lsub[s] = sb; psub[s] = sb;
  endtask

  // kind 0: data differs, 1: partner invalid, 2: sub-PC differs, 3: PC differs
  task automatic put_bad(int s, int kind, logic [7:0] pc, logic [1:0] sb);
    put_same(s, pc, sb);
    case (kind)
      0: pd[s] = 8'h5A;
      1: pv[s] = 1'b0;
      2: psub[s] = sb ^ 2'b01;
      default: ppc[s] = pc ^ 8'h80;
    endcase
  endtask

  task automatic bump();
    exp_cnt = (exp_cnt >= CMAX) ? CMAX : exp_cnt + 1;
  endtask

  // Inputs already driven at current negedge; checks redirect two edges later.
  task automatic expect_redirect(string req, logic [7:0] pc, logic [1:0] sb);
    tick(); idle();
    tick();
    chk(req, "flush", flush, 1);
    chk(req, "err_pulse", err_pulse, 1);
    chk(req, "redir_pc", redir_pc, pc);
    chk(req, "redir_sub", redir_sub, sb);
    chk(req, "retry_cnt", retry_cnt, exp_cnt);
    tick();
    chk(req, "flush drops", flush, 0);
  endtask

  task automatic retire(string req, logic [7:0] pc, logic [1:0] sb, bit closes);
    idle(); put_same(NS-1, pc, sb);
    tick(); idle();
    tick();
    if (closes) exp_cnt = 0;
    chk(req, "retry_cnt after retire", retry_cnt, exp_cnt);
    chk(req, "no flush on retire", flush, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    idle();
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    chk("R11", "flush", flush, 0);
    chk("R11", "err_pulse", err_pulse, 0);
    chk("R11", "redir_pc", redir_pc, 0);
    chk("R11", "retry_cnt", retry_cnt, 0);

    // R1 R2 R4: every stage, every kind of disagreement
    for (int s = 0; s < NS; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] pc;
        logic [1:0] sb;
        pc = 8'(16 * s + k + 1);
        sb = 2'((s + k) % 4);
        idle(); put_bad(s, k, pc, sb);
        bump();
        expect_redirect("R2", pc, sb);
        retire("R9", pc, sb, 1'b1);
      end
    end

    // R3: both sides invalid with differing contents
    for (int s = 0; s < NS; s++) begin
      idle();
      ld[s] = 8'h11; pd[s] = 8'h22; lpc[s] = 8'h33; ppc[s] = 8'h44; psub[s] = 2'd3;
      tick(); idle();
      tick();
      chk("R3", "flush", flush, 0);
      chk("R3", "retry_cnt", retry_cnt, 0);
    end

    // R5: every pair of stages failing together
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        idle();
        put_bad(i, 0, 8'(8'h80 + i), 2'd1);
        put_bad(j, 2, 8'(8'hC0 + j), 2'd2);
        bump();
        expect_redirect("R5", 8'(8'hC0 + j), 2'd2);
        retire("R5", 8'(8'hC0 + j), 2'd2, 1'b1);
      end
    end

    // R6: post-increment load, memory read fails on sub 1, base update sub 0 retires
    idle();
    put_bad(4, 0, 8'h40, 2'd1);
    put_same(5, 8'h40, 2'd0);
    bump();
    expect_redirect("R6", 8'h40, 2'd1);
    retire("R6", 8'h40, 2'd1, 1'b1);

    // R7: disagreement held three cycles yields one flush
    idle(); put_bad(2, 0, 8'h27, 2'd3);
    tick(); put_bad(2, 0, 8'h27, 2'd3);
    tick(); put_bad(2, 0, 8'h27, 2'd3);
    bump();
    chk("R7", "flush", flush, 1);
    tick(); idle();
    chk("R7", "flush second cycle", flush, 0);
    tick();
    chk("R7", "flush third cycle", flush, 0);
    chk("R7", "retry_cnt single", retry_cnt, 1);
    retire("R7", 8'h27, 2'd3, 1'b1);

    // R9: wrong-tag retire keeps retry open; R8: nested errors go to anchor
    idle(); put_bad(3, 0, 8'h33, 2'd2);
    bump();
    expect_redirect("R4", 8'h33, 2'd2);
    retire("R9", 8'h33, 2'd1, 1'b0);
    for (int n = 0; n < CMAX + 2; n++) begin
      idle(); put_bad(n % NS, 1, 8'(8'h01 + n), 2'd0);
      bump();
      expect_redirect("R8", 8'h33, 2'd2);
    end
    chk("R10", "saturated", retry_cnt, CMAX);
    retire("R10", 8'h33, 2'd2, 1'b1);

    // R10: close and fresh error in the same cycle
    idle(); put_bad(1, 0, 8'h51, 2'd1);
    bump();
    expect_redirect("R4", 8'h51, 2'd1);
    idle(); put_same(5, 8'h51, 2'd1); put_bad(2, 3, 8'h62, 2'd0);
    exp_cnt = 1;
    expect_redirect("R10", 8'h62, 2'd0);
    retire("R10", 8'h62, 2'd0, 1'b1);

    report();
  end

endmodule